// File: doc/BRIEF.md
# Priority-Assigned System Interrupt Controller

This block gathers 64 peripheral interrupt lines, held as two banks of 32, and steers each line to one of seven core interrupt levels. The levels are the general-purpose levels 7 through 13. The route for every line comes from its own 4-bit selector field. Each level gets one request wire toward the core. For each level the block also reports the index of the line that should be serviced first, which is the lowest-numbered line that is pending, enabled and assigned to that level.

Software sets the selector fields, the per-line enable bits and the per-line wake bits through a flat word-wide register port. The raw line levels are sampled into a status register each cycle and can be read back through the same port. When the core takes a level, it reports that level on a strobe. If no line is behind the taken level, the event is counted as spurious in a saturating counter that can also be read through the port.

Top module: `prio_sic`

## Requirements
- R1: After reset every line n has selector value n mod 7, all enable bits and wake bits are 0, and the spurious counter reads 0.
- R2: The status word for bank b (address 10+b) reads the level of line 32*b+i at bit i, as sampled at the previous clock edge.
- R3: Selector registers sit at addresses 0 to 7. The field of line n is bits (n mod 8)*4+3 down to (n mod 8)*4 of register n/8, and a written value reads back unchanged.
- R4: Selector value v in 0 to 6 assigns the line to output level index v, which is core level 7+v. Values 7 to 15 assign the line to no level.
- R5: Bit i of the enable word for bank b (address 8+b) enables line 32*b+i when it is 1. `lvl_req_o[v]` is 1 exactly when some line assigned to level v is both set in status and enabled.
- R6: `lvl_src_o[6*v+5:6*v]` carries the lowest-numbered line that is set in status, enabled and assigned to level v. It is 0 when `lvl_req_o[v]` is 0.
- R7: Bit i of the wake word for bank b (address 12+b) arms line 32*b+i. `wake_o` is the OR of status ANDed with the wake bits, whatever the enable bits hold.
- R8: A cycle with `take_vld_i` high counts as spurious when `lvl_req_o[take_lvl_i]` is 0 or when `take_lvl_i` is 7. A spurious cycle adds one to the counter, which reads at address 14. A take of a requesting level leaves the counter unchanged.
- R9: The spurious counter stops at 255 and holds that value under further spurious takes.
- R10: Writes to the status addresses, the counter address and address 15 change no state. Address 15 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 64 | Peripheral interrupt line levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| take_vld_i | input | 1 | Core takes a level this cycle |
| take_lvl_i | input | 3 | Level index being taken |
| lvl_req_o | output | 7 | Request per level index 0..6 (core levels 7..13) |
| lvl_src_o | output | 42 | Winning line index per level, 6 bits each |
| wake_o | output | 1 | Any armed line is active |

## Verification
A corrupted selector or enable bit appears at the ports as a level request on the wrong wire, or as the wrong winning index, on the first cycle in which the affected line is active. For that reason the bench drives each line alone and checks all seven levels. A scan that breaks ties in the wrong direction only shows when two lines share a level, so the bench also applies dense random line and enable patterns. A counter that misses an update or wraps past 255 is visible on readback right after the take strobes.

// File: rtl/prio_sic_pkg.sv
package prio_sic_pkg;
    localparam int LINES      = 64;
    localparam int BANK_W     = 32;
    localparam int FIELD_W    = 4;
    localparam int LEVELS     = 7;
    localparam int CNT_W      = 8;
    localparam int FPR        = BANK_W / FIELD_W;
    localparam int ASGN_REGS  = LINES / FPR;
    localparam int BANKS      = LINES / BANK_W;
    localparam int MASK_BASE  = ASGN_REGS;
    localparam int STAT_BASE  = MASK_BASE + BANKS;
    localparam int WAKE_BASE  = STAT_BASE + BANKS;
    localparam int CNT_ADDR   = WAKE_BASE + BANKS;
    localparam int ADDR_W     = $clog2(CNT_ADDR + 1);
    localparam int SRC_W      = $clog2(LINES);
    localparam int LVL_W      = $clog2(LEVELS + 1);

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [BANKS-1:0][BANK_W-1:0] bankvec_t;

    typedef struct packed {
        field_t [LINES-1:0] asgn;
        bankvec_t           mask;
        bankvec_t           stat;
        bankvec_t           wake;
    } regs_t;

    function automatic regs_t reset_regs();
        regs_t r;
        r = '0;
        for (int n = 0; n < LINES; n++) begin
            r.asgn[n] = field_t'(n % LEVELS);
        end
        return r;
    endfunction
endpackage

// File: rtl/prio_sic_regs.sv
module prio_sic_regs
    import prio_sic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BANK_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [BANK_W-1:0] rdata_o,
    output field_t [LINES-1:0] asgn_o,
    output logic [LINES-1:0]  pend_o,
    output logic              wake_o
);
    localparam regs_t RST_VAL = reset_regs();

    regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.stat = bankvec_t'(irq_i);
        if (wr_i) begin
            for (int r = 0; r < ASGN_REGS; r++) begin
                if (addr_i == ADDR_W'(r)) begin
                    for (int k = 0; k < FPR; k++) begin
                        r_d.asgn[r*FPR + k] = wdata_i[k*FIELD_W +: FIELD_W];
                    end
                end
            end
            for (int b = 0; b < BANKS; b++) begin
                if (addr_i == ADDR_W'(MASK_BASE + b)) r_d.mask[b] = wdata_i;
                if (addr_i == ADDR_W'(WAKE_BASE + b)) r_d.wake[b] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < ASGN_REGS; r++) begin
            if (addr_i == ADDR_W'(r)) begin
                for (int k = 0; k < FPR; k++) begin
                    rdata_o[k*FIELD_W +: FIELD_W] = r_q.asgn[r*FPR + k];
                end
            end
        end
        for (int b = 0; b < BANKS; b++) begin
            if (addr_i == ADDR_W'(MASK_BASE + b)) rdata_o = r_q.mask[b];
            if (addr_i == ADDR_W'(STAT_BASE + b)) rdata_o = r_q.stat[b];
            if (addr_i == ADDR_W'(WAKE_BASE + b)) rdata_o = r_q.wake[b];
        end
        if (addr_i == ADDR_W'(CNT_ADDR)) rdata_o = BANK_W'(cnt_i);
    end

    assign asgn_o = r_q.asgn;
    assign pend_o = LINES'(r_q.stat & r_q.mask);
    assign wake_o = |(r_q.stat & r_q.wake);

    // R2: status captures the line levels of the previous edge
    p_stat_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> r_q.stat == bankvec_t'($past(irq_i)));
    // R5: a write to the first enable word lands in that bank
    p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_W'(MASK_BASE)) |=> r_q.mask[0] == $past(wdata_i));
    // R10: without a write the selector fields never move
    p_asgn_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(r_q.asgn));
    // R10: write to a status address leaves enable and wake bits alone
    p_stat_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_W'(STAT_BASE)) |=> ($stable(r_q.mask) && $stable(r_q.wake)));
endmodule

// File: rtl/prio_sic_resolve.sv
module prio_sic_resolve
    import prio_sic_pkg::*;
#(
    parameter int LVL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  field_t [LINES-1:0] asgn_i,
    input  logic [LINES-1:0]  pend_i,
    output logic              req_o,
    output logic [SRC_W-1:0]  src_o
);
    logic [LINES-1:0] hit;

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            hit[i] = pend_i[i] && (asgn_i[i] == field_t'(LVL));
        end
        req_o = |hit;
        src_o = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (hit[i]) src_o = SRC_W'(i);
        end
    end

    logic [LINES-1:0] below;
    assign below = (LINES'(1) << src_o) - LINES'(1);

    // R6: the reported line really is pending and on this level
    p_src_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (pend_i[src_o] && asgn_i[src_o] == field_t'(LVL)));
    // R6: no lower-numbered line on this level is pending
    p_src_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> ((pend_i & below & hit) == '0));
    // R6: index parks at zero without a request
    p_src_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_o |-> src_o == '0);
endmodule

// File: rtl/prio_sic_spur.sv
module prio_sic_spur
    import prio_sic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spur_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (spur_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R8: each spurious take below the ceiling adds one
    p_cnt_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spur_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
    // R8: no spurious take, no change
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !spur_i |=> $stable(cnt_q));
    // R9: the ceiling is sticky
    p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/prio_sic.sv
module prio_sic
    import prio_sic_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LINES-1:0]        irq_i,
    input  logic                    reg_wr_i,
    input  logic [ADDR_W-1:0]       reg_addr_i,
    input  logic [BANK_W-1:0]       reg_wdata_i,
    output logic [BANK_W-1:0]       reg_rdata_o,
    input  logic                    take_vld_i,
    input  logic [LVL_W-1:0]        take_lvl_i,
    output logic [LEVELS-1:0]       lvl_req_o,
    output logic [LEVELS*SRC_W-1:0] lvl_src_o,
    output logic                    wake_o
);
    field_t [LINES-1:0] asgn;
    logic [LINES-1:0]   pend;
    logic [CNT_W-1:0]   cnt;
    logic               spur;

    prio_sic_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_i   (irq_i),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .cnt_i   (cnt),
        .rdata_o (reg_rdata_o),
        .asgn_o  (asgn),
        .pend_o  (pend),
        .wake_o  (wake_o)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        prio_sic_resolve #(.LVL(l)) u_res (
            .clk    (clk),
            .rst_n  (rst_n),
            .asgn_i (asgn),
            .pend_i (pend),
            .req_o  (lvl_req_o[l]),
            .src_o  (lvl_src_o[l*SRC_W +: SRC_W])
        );
    end

    always_comb begin
        spur = 1'b0;
        if (take_vld_i) begin
            spur = 1'b1;
            for (int l = 0; l < LEVELS; l++) begin
                if (take_lvl_i == LVL_W'(l) && lvl_req_o[l]) spur = 1'b0;
            end
        end
    end

    prio_sic_spur u_spur (
        .clk    (clk),
        .rst_n  (rst_n),
        .spur_i (spur),
        .cnt_o  (cnt)
    );

    // R5: no enabled pending line means no request on any level
    p_no_req_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (lvl_req_o == '0));
    // R7: wake output needs some active line
    p_wake_needs_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(irq_i) != '0);
endmodule

// File: tb/prio_sic_tb_top.sv
module prio_sic_tb_top;
    import prio_sic_pkg::*;

    localparam int CLK_P = 10;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [LINES-1:0]        irq = '0;
    logic                    wr = 1'b0;
    logic [ADDR_W-1:0]       addr = '0;
    logic [BANK_W-1:0]       wdata = '0;
    logic [BANK_W-1:0]       rdata;
    logic                    take_vld = 1'b0;
    logic [LVL_W-1:0]        take_lvl = '0;
    logic [LEVELS-1:0]       req;
    logic [LEVELS*SRC_W-1:0] src;
    logic                    wake;

    int n_run = 0;
    int n_fail = 0;

    logic [3:0]  m_field [LINES];
    logic [63:0] m_mask, m_wake;
    int          m_cnt;

    always #(CLK_P/2) clk = ~clk;

    prio_sic dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .take_vld_i(take_vld), .take_lvl_i(take_lvl),
        .lvl_req_o(req), .lvl_src_o(src), .wake_o(wake)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = ADDR_W'(a);
        #1;
        d = rdata;
    endtask

    task automatic set_irq(input logic [63:0] v);
        @(negedge clk);
        irq = v;
        @(negedge clk);
        #1;
    endtask

    task automatic write_fields();
        for (int r = 0; r < ASGN_REGS; r++) begin
            logic [31:0] w;
            for (int k = 0; k < FPR; k++) w[k*4 +: 4] = m_field[r*FPR + k];
            wr_reg(r, w);
        end
    endtask

    task automatic write_mask();
        wr_reg(MASK_BASE, m_mask[31:0]);
        wr_reg(MASK_BASE + 1, m_mask[63:32]);
    endtask

    // R4 R5 R6: expected level outputs from the bench model
    task automatic chk_levels(input string tag);
        #1;
        for (int l = 0; l < LEVELS; l++) begin
            logic e_req;
            int   e_src;
            e_req = 1'b0; e_src = 0;
            for (int i = LINES - 1; i >= 0; i--) begin
                if (irq[i] && m_mask[i] && m_field[i] == 4'(l)) begin
                    e_req = 1'b1; e_src = i;
                end
            end
            chk({tag, " req"}, 64'(req[l]), 64'(e_req));
            chk({tag, " src"}, 64'(src[l*SRC_W +: SRC_W]), 64'(e_src));
        end
    endtask

    task automatic take(input int l);
        logic e_spur;
        e_spur = 1'b1;
        #1;
        if (l < LEVELS && req[l]) e_spur = 1'b0;
        @(negedge clk);
        take_vld = 1'b1; take_lvl = LVL_W'(l);
        @(negedge clk);
        take_vld = 1'b0;
        if (e_spur && m_cnt < 255) m_cnt++;
    endtask

    function automatic logic [63:0] nxt(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] seed;
        m_cnt = 0;
        for (int n = 0; n < LINES; n++) m_field[n] = 4'(n % 7);
        m_mask = '0; m_wake = '0;
        irq = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int r = 0; r < ASGN_REGS; r++) begin
            logic [31:0] e;
            for (int k = 0; k < FPR; k++) e[k*4 +: 4] = 4'((r*FPR + k) % 7);
            rd_reg(r, d);
            chk("R1 default selector", 64'(d), 64'(e));
        end
        rd_reg(MASK_BASE, d);     chk("R1 enable bank0", 64'(d), 0);
        rd_reg(MASK_BASE + 1, d); chk("R1 enable bank1", 64'(d), 0);
        rd_reg(WAKE_BASE, d);     chk("R1 wake bank0", 64'(d), 0);
        rd_reg(CNT_ADDR, d);      chk("R1 counter", 64'(d), 0);
        chk("R1 no request", 64'(req), 0);
        chk("R1 no wake", 64'(wake), 0);
        // R2 status follows lines
        rd_reg(STAT_BASE, d);     chk("R2 status bank0", 64'(d), 64'hffff_ffff);
        set_irq(64'h0123_4567_89ab_cdef);
        rd_reg(STAT_BASE, d);     chk("R2 status bank0", 64'(d), 64'h89ab_cdef);
        rd_reg(STAT_BASE + 1, d); chk("R2 status bank1", 64'(d), 64'h0123_4567);

        // R5 R6 default mapping, all enabled
        m_mask = '1; write_mask();
        set_irq('1);
        chk_levels("R6 default map");

        // R3 R4 selector sweep including unassigned values
        for (int n = 0; n < LINES; n++) m_field[n] = 4'((n * 5 + 3) % 16);
        write_fields();
        for (int r = 0; r < ASGN_REGS; r++) begin
            logic [31:0] e;
            for (int k = 0; k < FPR; k++) e[k*4 +: 4] = m_field[r*FPR + k];
            rd_reg(r, d);
            chk("R3 selector readback", 64'(d), 64'(e));
        end
        for (int i = 0; i < LINES; i++) begin
            set_irq(64'd1 << i);
            chk_levels("R4 single line");
        end

        // R5 R6 dense random lines, enables and selectors
        seed = 64'h9e37_79b9_7f4a_7c15;
        for (int it = 0; it < 40; it++) begin
            seed = nxt(seed);
            if (it % 8 == 0) begin
                for (int n = 0; n < LINES; n++) m_field[n] = 4'((seed >> (n % 60)) % 9);
                write_fields();
            end
            m_mask = seed ^ (seed << 7);
            if (it == 5) m_mask = '0;
            write_mask();
            seed = nxt(seed);
            set_irq(seed);
            chk_levels("R5 R6 random");
        end

        // R7 wake, independent of enables
        m_mask = '0; write_mask();
        m_wake = 64'h8000_0000_0000_0001;
        wr_reg(WAKE_BASE, m_wake[31:0]);
        wr_reg(WAKE_BASE + 1, m_wake[63:32]);
        set_irq(64'h0000_0000_0000_0001); chk("R7 wake low line", 64'(wake), 1);
        set_irq(64'h7fff_ffff_ffff_fffe); chk("R7 wake unarmed lines", 64'(wake), 0);
        set_irq(64'h8000_0000_0000_0000); chk("R7 wake high line", 64'(wake), 1);
        chk("R7 no request while disabled", 64'(req), 0);

        // R8 spurious counting
        set_irq('0);
        for (int l = 0; l <= LEVELS; l++) take(l);
        rd_reg(CNT_ADDR, d); chk("R8 spurious count idle", 64'(d), 64'(m_cnt));
        m_mask = '1; write_mask();
        set_irq('1);
        for (int l = 0; l <= LEVELS; l++) take(l);
        rd_reg(CNT_ADDR, d); chk("R8 takes with requests", 64'(d), 64'(m_cnt));

        // R9 saturation
        for (int t = 0; t < 300; t++) take(LEVELS);
        rd_reg(CNT_ADDR, d); chk("R9 saturated", 64'(d), 255);
        take(LEVELS);
        rd_reg(CNT_ADDR, d); chk("R9 stays saturated", 64'(d), 255);

        // R10 ignored writes
        wr_reg(STAT_BASE, 32'h0);
        rd_reg(STAT_BASE, d); chk("R10 status write ignored", 64'(d), 64'hffff_ffff);
        wr_reg(CNT_ADDR, 32'h0);
        rd_reg(CNT_ADDR, d); chk("R10 counter write ignored", 64'(d), 255);
        wr_reg(15, 32'hffff_ffff);
        rd_reg(15, d); chk("R10 address 15 reads zero", 64'(d), 0);
        rd_reg(MASK_BASE, d); chk("R10 enables untouched", 64'(d), 64'hffff_ffff);
        chk_levels("R10 levels untouched");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule